// File: doc/BRIEF.md
# Condition Register Lookup-Table Logic Unit

This block holds a 32-bit condition register, organised as eight 4-bit fields, and changes it with lookup-table logic operations. Each operation builds a small index out of condition register bits, with the destination bit or field always one of the inputs. It then uses the index to pick a result bit from a truth table. The table is either an 8-bit immediate or the contents of another field. Because the destination takes part in its own lookup, every operation is a read-modify-write of the register.

Four operations are provided. There are two single-bit forms, a ternary one driven by the immediate and a binary one whose table is a register field. There are two whole-field forms, binary and ternary, which write only the positions selected by a 4-bit mask. A caller presents the operands with a one-cycle start strobe. The register is updated at the next rising edge, and a done pulse marks that edge. A load port lets the environment preset the whole register, and a read port shows its value at all times.

Top module: `crlut_unit`

## Requirements
- R1: While rst_n is low at a rising clock edge, the register is cleared to zero and done is driven low.
- R2: Bits are numbered MSB-first: register bit n is cr_q[31-n]. Field n is the value cr_q[31-4n:28-4n], and bit i of a field value (i = 0 is the least significant bit) is cr_q[28-4n+i]. Bit k of imm and mask is the vector bit imm[k] / mask[k].
- R3: op = 0 (single-bit ternary) writes imm[idx] into bit bt, where idx = {bit bt, bit ba, bit bb} and bit bt is the MSB. All bits are read before the write, and the operands may name the same bit.
- R4: op = 1 (single-bit binary) writes T[idx] into bit bt, where T is the value of field bfb and idx = {bit bt, bit ba} with bit bt as the MSB. The table field may contain bt or ba.
- R5: op = 2 (field binary) computes, for each i in 0..3, r[i] = B[{D[i], A[i]}]. D, A and B are the old values of fields bf, bfa and bfb. Field bf becomes r where mask[i] = 1 and keeps D[i] where mask[i] = 0.
- R6: op = 3 (field ternary) computes, for each i, r[i] = imm[{D[i], A[i], B[i]}], with D from field bf as the MSB. It applies r only where mask[i] = 1.
- R7: A single-bit operation changes no bit other than bt. A field operation changes no bit outside field bf, and no bit whose mask bit is 0.
- R8: done is high for exactly one cycle, after the edge that samples start = 1 with load_en = 0. The register update appears at that same edge.
- R9: load_en = 1 writes load_val into the register at the next edge. It takes priority over a simultaneous start, which then causes no update and no done.
- R10: With start and load_en both low, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle strobe; operands are sampled with it |
| op | input | 2 | Operation select (0 bit ternary, 1 bit binary, 2 field binary, 3 field ternary) |
| bt | input | 5 | Destination bit for single-bit operations |
| ba | input | 5 | Second source bit for single-bit operations |
| bb | input | 5 | Third source bit for the single-bit ternary operation |
| bf | input | 3 | Destination field for field operations |
| bfa | input | 3 | Source field A for field operations |
| bfb | input | 3 | Table field (bit binary) or source field B (field operations) |
| imm | input | 8 | Truth-table immediate for ternary operations |
| mask | input | 4 | Write mask for field operations |
| load_en | input | 1 | Write enable for the preload port |
| load_val | input | 32 | Value written when load_en is high |
| cr_q | output | 32 | Current register value |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that start and load_en are sampled only after reset has been released. They also assume that the operand fields are stable during the cycle in which start is high. The locality checks compare each new register value with the one before it, so they need no model of the lookup. The stimulus drives every input on the falling edge, and it raises start for exactly one cycle at a time. Each operation therefore has settled operands and is followed by an idle cycle before the next preload or operation.

// File: rtl/crlut_pkg.sv
// Package crlut_pkg
// Shared constants and the operation encoding of the condition register
// lookup-table unit. Assumes 4-bit fields, as the binary table is one field.
package crlut_pkg;

    localparam int FIELD_W = 4;

    typedef enum logic [1:0] {
        OP_BIT_TERN = 2'd0,
        OP_BIT_BIN  = 2'd1,
        OP_FLD_BIN  = 2'd2,
        OP_FLD_TERN = 2'd3
    } crlut_op_e;

endpackage

// File: rtl/crlut_bit_unit.sv
// Module crlut_bit_unit
// Computes the new value of one destination bit for the single-bit forms.
// Assumes MSB-first bit numbering and that the table field is FIELD_W wide.
// Purely combinational; the caller places the bit into the register.
module crlut_bit_unit
    import crlut_pkg::*;
#(
    parameter  int NUM_FIELDS = 8,
    localparam int CR_W       = NUM_FIELDS * FIELD_W,
    localparam int BIT_IDX_W  = $clog2(CR_W),
    localparam int FLD_IDX_W  = $clog2(NUM_FIELDS)
) (
    input  logic [CR_W-1:0]      cr,
    input  logic                 use_tern,
    input  logic [BIT_IDX_W-1:0] bt,
    input  logic [BIT_IDX_W-1:0] ba,
    input  logic [BIT_IDX_W-1:0] bb,
    input  logic [FLD_IDX_W-1:0] bfb,
    input  logic [7:0]           imm,
    output logic                 bit_out
);

    logic [CR_W-1:0]    msb_view;
    logic [FIELD_W-1:0] fld [NUM_FIELDS];

    // MSB-first view of the register, so bit n is msb_view[n]
    for (genvar k = 0; k < CR_W; k++) begin : g_view
        assign msb_view[k] = cr[CR_W-1-k];
    end

    // Field values, least significant bit is the last bit of the field
    for (genvar n = 0; n < NUM_FIELDS; n++) begin : g_fld
        assign fld[n] = cr[CR_W-1-FIELD_W*n -: FIELD_W];
    end

    logic [2:0] idx3;
    logic [1:0] idx2;
    logic [FIELD_W-1:0] table_fld;

    // Select the index bits and the table, then look up
    always_comb begin
        idx3      = {msb_view[bt], msb_view[ba], msb_view[bb]};
        idx2      = {msb_view[bt], msb_view[ba]};
        table_fld = fld[bfb];
        bit_out   = use_tern ? imm[idx3] : table_fld[idx2];
    end

endmodule

// File: rtl/crlut_field_unit.sv
// Module crlut_field_unit
// Computes the new value of a destination field for the field forms.
// Each bit position i has its own lookup. The old destination bit is the
// index MSB, and the mask keeps the old bit where it is zero.
module crlut_field_unit
    import crlut_pkg::*;
#(
    parameter  int NUM_FIELDS = 8,
    localparam int CR_W       = NUM_FIELDS * FIELD_W,
    localparam int FLD_IDX_W  = $clog2(NUM_FIELDS)
) (
    input  logic [CR_W-1:0]      cr,
    input  logic                 use_tern,
    input  logic [FLD_IDX_W-1:0] bf,
    input  logic [FLD_IDX_W-1:0] bfa,
    input  logic [FLD_IDX_W-1:0] bfb,
    input  logic [7:0]           imm,
    input  logic [FIELD_W-1:0]   mask,
    output logic [FIELD_W-1:0]   fld_out
);

    logic [FIELD_W-1:0] fld [NUM_FIELDS];
    logic [FIELD_W-1:0] dst_old, src_a, src_b;

    // Field values of the register
    for (genvar n = 0; n < NUM_FIELDS; n++) begin : g_fld
        assign fld[n] = cr[CR_W-1-FIELD_W*n -: FIELD_W];
    end

    assign dst_old = fld[bf];
    assign src_a   = fld[bfa];
    assign src_b   = fld[bfb];

    // One lookup per bit position, merged under the mask
    for (genvar i = 0; i < FIELD_W; i++) begin : g_pos
        logic [2:0] idx3;
        logic [1:0] idx2;
        logic       res;
        always_comb begin
            idx3       = {dst_old[i], src_a[i], src_b[i]};
            idx2       = {dst_old[i], src_a[i]};
            res        = use_tern ? imm[idx3] : src_b[idx2];
            fld_out[i] = mask[i] ? res : dst_old[i];
        end
    end

endmodule

// File: rtl/crlut_unit.sv
// Module crlut_unit
// Holds the condition register and applies one lookup-table operation per
// start strobe. Assumes operands are valid in the start cycle. The preload
// port wins over start. Reset is synchronous and active low.
module crlut_unit
    import crlut_pkg::*;
#(
    parameter  int NUM_FIELDS = 8,
    localparam int CR_W       = NUM_FIELDS * FIELD_W,
    localparam int BIT_IDX_W  = $clog2(CR_W),
    localparam int FLD_IDX_W  = $clog2(NUM_FIELDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [1:0]           op,
    input  logic [BIT_IDX_W-1:0] bt,
    input  logic [BIT_IDX_W-1:0] ba,
    input  logic [BIT_IDX_W-1:0] bb,
    input  logic [FLD_IDX_W-1:0] bf,
    input  logic [FLD_IDX_W-1:0] bfa,
    input  logic [FLD_IDX_W-1:0] bfb,
    input  logic [7:0]           imm,
    input  logic [FIELD_W-1:0]   mask,
    input  logic                 load_en,
    input  logic [CR_W-1:0]      load_val,
    output logic [CR_W-1:0]      cr_q,
    output logic                 done
);

    crlut_op_e op_e;
    logic      is_field;
    logic      bit_new;
    logic [FIELD_W-1:0] fld_new;
    logic [CR_W-1:0]    cr_next;

    assign op_e     = crlut_op_e'(op);
    assign is_field = (op_e == OP_FLD_BIN) || (op_e == OP_FLD_TERN);

    crlut_bit_unit #(.NUM_FIELDS(NUM_FIELDS)) u_bit (
        .cr       (cr_q),
        .use_tern (op_e == OP_BIT_TERN),
        .bt       (bt),
        .ba       (ba),
        .bb       (bb),
        .bfb      (bfb),
        .imm      (imm),
        .bit_out  (bit_new)
    );

    crlut_field_unit #(.NUM_FIELDS(NUM_FIELDS)) u_fld (
        .cr       (cr_q),
        .use_tern (op_e == OP_FLD_TERN),
        .bf       (bf),
        .bfa      (bfa),
        .bfb      (bfb),
        .imm      (imm),
        .mask     (mask),
        .fld_out  (fld_new)
    );

    // Place the new bit or field into the register image, bit by bit
    for (genvar k = 0; k < CR_W; k++) begin : g_merge
        localparam logic [FLD_IDX_W-1:0] K_FLD = FLD_IDX_W'(k / FIELD_W);
        localparam logic [BIT_IDX_W-1:0] K_BIT = BIT_IDX_W'(k);
        localparam int                   K_POS = FIELD_W - 1 - (k % FIELD_W);
        always_comb begin
            if (is_field)
                cr_next[CR_W-1-k] = (bf == K_FLD) ? fld_new[K_POS] : cr_q[CR_W-1-k];
            else
                cr_next[CR_W-1-k] = (bt == K_BIT) ? bit_new : cr_q[CR_W-1-k];
        end
    end

    // Register update: reset, then preload, then operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr_q <= '0;
            done <= 1'b0;
        end else begin
            done <= start && !load_en;
            if (load_en)
                cr_q <= load_val;
            else if (start)
                cr_q <= cr_next;
        end
    end

    // Bits a field operation may touch: field bf under the mask
    logic [CR_W-1:0] fld_allow;
    always_comb begin
        for (int k = 0; k < CR_W; k++)
            fld_allow[CR_W-1-k] = (bf == FLD_IDX_W'(k / FIELD_W)) &&
                                  mask[FIELD_W-1-(k % FIELD_W)];
    end

    // R8: done pulse only follows an accepted start
    p_done_after_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !load_en) |=> done);
    p_done_needs_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!start || load_en) |=> !done);

    // R9: preload lands in the register
    p_load_writes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (cr_q == $past(load_val)));

    // R10: idle cycles keep the register
    p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !load_en) |=> $stable(cr_q));

    // R7: a single-bit operation changes at most one bit
    p_bit_local_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !load_en && !is_field) |=> ($countones(cr_q ^ $past(cr_q)) <= 1));

    // R7: a field operation stays inside the masked destination field
    p_field_local_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !load_en && is_field) |=> (((cr_q ^ $past(cr_q)) & ~$past(fld_allow)) == '0));

endmodule

// File: tb/crlut_unit_bench.sv
// Bench for crlut_unit: a vector table walked by one loop, then directed
// tests for reset, pulse width, preload priority and idle hold.
module crlut_unit_bench;

    typedef struct packed {
        logic [31:0] pre;
        logic [1:0]  op;
        logic [4:0]  bt;
        logic [4:0]  ba;
        logic [4:0]  bb;
        logic [2:0]  bf;
        logic [2:0]  bfa;
        logic [2:0]  bfb;
        logic [7:0]  imm;
        logic [3:0]  mask;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        // R3: index 0 selects imm[0], sets bit 5
        '{32'h0000_0000, 2'd0, 5'd5,  5'd0,  5'd0, 3'd0, 3'd0, 3'd0, 8'h01, 4'h0, 32'h0400_0000},
        // R3: destination is index MSB, index 4 -> imm[4]=0 clears bit 0
        '{32'h8000_0000, 2'd0, 5'd0,  5'd31, 5'd1, 3'd0, 3'd0, 3'd0, 8'hEF, 4'h0, 32'h0000_0000},
        // R3: all operands name bit 31, index 7 -> imm[7]=0
        '{32'h0000_0001, 2'd0, 5'd31, 5'd31, 5'd31, 3'd0, 3'd0, 3'd0, 8'h7F, 4'h0, 32'h0000_0000},
        // R4: table field 6 = A, index 1 -> 1 sets bit 2
        '{32'h0000_00A0, 2'd1, 5'd2,  5'd24, 5'd0, 3'd0, 3'd0, 3'd6, 8'h00, 4'h0, 32'h2000_00A0},
        // R4: destination inside the table field, index 2 -> 0 clears bit 24
        '{32'h0000_00A0, 2'd1, 5'd24, 5'd27, 5'd0, 3'd0, 3'd0, 3'd6, 8'h00, 4'h0, 32'h0000_0020},
        // R5: xor table, full mask
        '{32'h0CA6_0000, 2'd2, 5'd0,  5'd0,  5'd0, 3'd1, 3'd2, 3'd3, 8'h00, 4'hF, 32'h06A6_0000},
        // R5: partial mask keeps old upper bits
        '{32'h0CA6_0000, 2'd2, 5'd0,  5'd0,  5'd0, 3'd1, 3'd2, 3'd3, 8'h00, 4'h3, 32'h0EA6_0000},
        // R6: majority immediate, full mask
        '{32'h9000_3005, 2'd3, 5'd0,  5'd0,  5'd0, 3'd0, 3'd7, 3'd4, 8'hE8, 4'hF, 32'h1000_3005},
        // R6: zero mask leaves the field unchanged
        '{32'h9000_3005, 2'd3, 5'd0,  5'd0,  5'd0, 3'd0, 3'd7, 3'd4, 8'hFF, 4'h0, 32'h9000_3005},
        // R5: all three fields are field 5
        '{32'h0000_0900, 2'd2, 5'd0,  5'd0,  5'd0, 3'd5, 3'd5, 3'd5, 8'h00, 4'hF, 32'h0000_0F00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = '0;
    logic [4:0]  bt = '0, ba = '0, bb = '0;
    logic [2:0]  bf = '0, bfa = '0, bfb = '0;
    logic [7:0]  imm = '0;
    logic [3:0]  mask = '0;
    logic        load_en = 1'b0;
    logic [31:0] load_val = '0;
    logic [31:0] cr_q;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    crlut_unit u_crlut_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .bt(bt), .ba(ba), .bb(bb), .bf(bf), .bfa(bfa), .bfb(bfb),
        .imm(imm), .mask(mask), .load_en(load_en), .load_val(load_val),
        .cr_q(cr_q), .done(done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic preload(input logic [31:0] v);
        load_en = 1'b1; load_val = v;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic run(input vec_t v);
        op = v.op; bt = v.bt; ba = v.ba; bb = v.bb;
        bf = v.bf; bfa = v.bfa; bfb = v.bfb; imm = v.imm; mask = v.mask;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 cr", cr_q, 32'h0);
        check("R1 done", {31'b0, done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            preload(VECS[i].pre);
            check("R9 preload", cr_q, VECS[i].pre);
            run(VECS[i]);
            check("R2 R7 result", cr_q, VECS[i].exp);
            check("R8 done high", {31'b0, done}, 32'h1);
            @(negedge clk);
            check("R8 done one cycle", {31'b0, done}, 32'h0);
            check("R10 hold", cr_q, VECS[i].exp);
        end

        // R9: preload beats a simultaneous start, no done
        preload(32'h1234_5678);
        op = 2'd0; bt = 5'd0; imm = 8'hFF; start = 1'b1;
        load_en = 1'b1; load_val = 32'hCAFE_0001;
        @(negedge clk);
        start = 1'b0; load_en = 1'b0;
        check("R9 priority", cr_q, 32'hCAFE_0001);
        check("R9 no done", {31'b0, done}, 32'h0);

        // R10: several idle cycles with operands moving
        bt = 5'd3; imm = 8'hAA; mask = 4'hF; op = 2'd3;
        repeat (4) @(negedge clk);
        check("R10 idle", cr_q, 32'hCAFE_0001);

        // R1: reset in mid-run clears the register
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reclear", cr_q, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule